// File: doc/BRIEF.md
# UDP Transmit Frame Buffer

This block sits between a producer of 64-bit payload words and the IP layer of a transmit path. The producer presents one word per cycle with a valid strobe. It raises an end-of-frame strobe together with the final word. In that same closing cycle it also supplies the destination IPv4 address and UDP port for the frame. Payload words are kept in a deep word FIFO. Each closed frame leaves a small descriptor (address, port, word count) in a separate queue. The producer can therefore fill the next frame while earlier ones are still leaving.

On the downstream side, the block emits each queued frame on a 64-bit valid/ready stream. The first word is an 8-byte UDP header, built from a configured source port, the captured destination port, the computed UDP length and a zero checksum. The buffered payload words follow, and the last of them carries a last flag. The captured destination address travels as sideband for the whole frame.

An almost-full status asks the producer to pause before the FIFO runs out of room. Pushing a word into a full FIFO, or closing a frame while the descriptor queue is full, sets a sticky overflow flag. Once that flag is set, the whole transmit path stops until reset.

Top module: `udp_tx_framer`

## Requirements
- R1: While reset is high and in the cycle after it, outValid, almostFull and overflow are 0. Reset empties both the payload FIFO and the descriptor queue.
- R2: The first word of every frame is {cfgSrcPort[15:0] in bits 63:48, destination port in bits 47:32, UDP length in bits 31:16, 16'h0000 in bits 15:0}. The UDP length is 8 + 8 x (payload word count).
- R3: The header is followed by exactly the words accepted with inValid high, in order. Cycles with inValid low store nothing. outLast is 1 only on the final payload word.
- R4: inDestIp and inDestPort are used only in the cycle where inValid and inLast are both high. outDestIp equals the captured address on every word of that frame.
- R5: A frame of 1088 words (8704 bytes) is buffered whole and sent without overflow.
- R6: Up to DESC_DEPTH (default 4) closed frames can wait at once, and new words can be written while an earlier frame drains. Frames leave in the order they were closed.
- R7: almostFull is 1 exactly when the payload FIFO holds at least DEPTH - AFULL_MARGIN words (default 2048 - 16 = 2032).
- R8: A valid word offered while the FIFO holds DEPTH words is dropped and sets overflow. Closing a frame while DESC_DEPTH descriptors are queued does the same. Overflow stays 1 until reset.
- R9: While overflow is 1, no word or descriptor is stored and outValid stays 0.
- R10: While outValid is 1 and outReady is 0, outValid, outData, outLast and outDestIp hold their values, unless overflow locks the path.
- R11: After a reset that follows an overflow, the block accepts and sends frames normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfgSrcPort | input | 16 | UDP source port placed in every header |
| inData | input | 64 | Payload word |
| inValid | input | 1 | Payload word present this cycle |
| inLast | input | 1 | Final word of the frame, qualified by inValid |
| inDestIp | input | 32 | Destination IPv4 address, used on the closing cycle |
| inDestPort | input | 16 | Destination UDP port, used on the closing cycle |
| almostFull | output | 1 | Payload FIFO nearly full |
| overflow | output | 1 | Sticky overflow, path locked |
| outData | output | 64 | Header or payload word |
| outValid | output | 1 | outData is presented |
| outReady | input | 1 | Downstream takes the word when outValid is also high |
| outLast | output | 1 | Final payload word of a frame |
| outDestIp | output | 32 | Destination address of the frame being sent |

## Verification
A table of frames is sent one at a time. The frames vary in length from one word upward, in gaps in the valid strobe, and in whether the downstream is always ready or throttled. This separates correct word counting and header length from merely passing data through, and it shows that idle input cycles store nothing. Off the closing cycle, the address and port inputs carry inverted junk, so a design that samples them at any other time gives a wrong header or sideband. Further cases cover back-to-back frames, a full 1088-word frame held behind a stalled output, filling the FIFO up to the almost-full threshold and then to overflow, overflowing the descriptor queue, and recovery after reset.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;

  localparam int WORD_W = 64;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic popPayload;
    logic popDesc;
    logic selHeader;
  } txStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY
  } txState_t;

  // UDP length: 8 header bytes plus 8 bytes per payload word
  function automatic logic [15:0] udpLength(input logic [15:0] words);
    return 16'((words << 3) + 16'd8);
  endfunction

endpackage

// File: rtl/udp_tx_datapath.sv
module udp_tx_datapath
  import udp_tx_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AFULL_MARGIN = 16,
  parameter int DESC_DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int DPTR_W = $clog2(DESC_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cfgSrcPort,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [31:0]       inDestIp,
  input  logic [15:0]       inDestPort,
  input  txStrobes_t        strobes,
  output logic              descEmpty,
  output logic [CNT_W-1:0]  descWords,
  output logic              overflow,
  output logic              almostFull,
  output logic [WORD_W-1:0] outData,
  output logic [31:0]       outDestIp
);

  logic [WORD_W-1:0] payMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  occ, frameCnt;

  logic [31:0]       dIp    [DESC_DEPTH];
  logic [15:0]       dPort  [DESC_DEPTH];
  logic [CNT_W-1:0]  dWords [DESC_DEPTH];
  logic [DPTR_W-1:0] dWrPtr, dRdPtr;
  logic [DPTR_W:0]   dCount;

  logic payFull, descFull, wrAttempt, closeBlocked, wrOk, ovfSet, pushDesc;
  logic [WORD_W-1:0] hdrWord;

  assign payFull      = (occ == CNT_W'(DEPTH));
  assign descFull     = (dCount == (DPTR_W+1)'(DESC_DEPTH));
  assign descEmpty    = (dCount == '0);
  assign wrAttempt    = inValid && !overflow;
  assign closeBlocked = inLast && descFull;
  assign wrOk         = wrAttempt && !payFull && !closeBlocked;
  assign ovfSet       = wrAttempt && (payFull || closeBlocked);
  assign pushDesc     = wrOk && inLast;
  assign almostFull   = (occ >= CNT_W'(DEPTH - AFULL_MARGIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      occ      <= '0;
      frameCnt <= '0;
      overflow <= 1'b0;
      dWrPtr   <= '0;
      dRdPtr   <= '0;
      dCount   <= '0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + PTR_W'(1);
      if (strobes.popPayload) rdPtr <= rdPtr + PTR_W'(1);
      occ <= occ + CNT_W'(wrOk) - CNT_W'(strobes.popPayload);
      if (wrOk) frameCnt <= inLast ? '0 : frameCnt + CNT_W'(1);
      if (ovfSet) overflow <= 1'b1;
      if (pushDesc) dWrPtr <= dWrPtr + DPTR_W'(1);
      if (strobes.popDesc) dRdPtr <= dRdPtr + DPTR_W'(1);
      dCount <= dCount + (DPTR_W+1)'(pushDesc) - (DPTR_W+1)'(strobes.popDesc);
    end
  end

  always_ff @(posedge clk) begin
    if (wrOk) payMem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (pushDesc) begin
      dIp[dWrPtr]    <= inDestIp;
      dPort[dWrPtr]  <= inDestPort;
      dWords[dWrPtr] <= frameCnt + CNT_W'(1);
    end
  end

  assign descWords = dWords[dRdPtr];
  assign outDestIp = dIp[dRdPtr];
  assign hdrWord   = {cfgSrcPort, dPort[dRdPtr], udpLength(16'(descWords)), 16'h0000};
  assign outData   = strobes.selHeader ? hdrWord : payMem[rdPtr];

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    overflow |=> ($stable(wrPtr) && $stable(dCount))); // R9
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    strobes.popPayload |-> (occ != '0)); // R3

endmodule

// File: rtl/udp_tx_control.sv
module udp_tx_control
  import udp_tx_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             descEmpty,
  input  logic [CNT_W-1:0] descWords,
  input  logic             overflow,
  input  logic             outReady,
  output txStrobes_t       strobes,
  output logic             outValid,
  output logic             outLast
);

  txState_t         state;
  logic [CNT_W-1:0] remain;
  logic             fire;

  always_comb begin
    outValid           = (state != ST_IDLE) && !overflow;
    fire               = outValid && outReady;
    outLast            = (state == ST_PAY) && (remain == CNT_W'(1)) && !overflow;
    strobes.selHeader  = (state == ST_HDR);
    strobes.popPayload = fire && (state == ST_PAY);
    strobes.popDesc    = strobes.popPayload && (remain == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      remain <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (!descEmpty && !overflow) state <= ST_HDR;
        ST_HDR: if (fire) begin
          state  <= ST_PAY;
          remain <= descWords;
        end
        ST_PAY: if (fire) begin
          remain <= remain - CNT_W'(1);
          if (remain == CNT_W'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PAY_NEEDS_DESC: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !descEmpty); // R6

endmodule

// File: rtl/udp_tx_framer.sv
module udp_tx_framer
  import udp_tx_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AFULL_MARGIN = 16,
  parameter int DESC_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] cfgSrcPort,
  input  logic [63:0] inData,
  input  logic        inValid,
  input  logic        inLast,
  input  logic [31:0] inDestIp,
  input  logic [15:0] inDestPort,
  output logic        almostFull,
  output logic        overflow,
  output logic [63:0] outData,
  output logic        outValid,
  input  logic        outReady,
  output logic        outLast,
  output logic [31:0] outDestIp
);

  localparam int CNT_W = $clog2(DEPTH) + 1;

  txStrobes_t       strobes;
  logic             descEmpty;
  logic [CNT_W-1:0] descWords;

  udp_tx_datapath #(
    .DEPTH(DEPTH), .AFULL_MARGIN(AFULL_MARGIN), .DESC_DEPTH(DESC_DEPTH)
  ) dp (
    .clk(clk), .rst(rst), .cfgSrcPort(cfgSrcPort),
    .inData(inData), .inValid(inValid), .inLast(inLast),
    .inDestIp(inDestIp), .inDestPort(inDestPort),
    .strobes(strobes), .descEmpty(descEmpty), .descWords(descWords),
    .overflow(overflow), .almostFull(almostFull),
    .outData(outData), .outDestIp(outDestIp)
  );

  udp_tx_control #(.CNT_W(CNT_W)) ctl (
    .clk(clk), .rst(rst), .descEmpty(descEmpty), .descWords(descWords),
    .overflow(overflow), .outReady(outReady),
    .strobes(strobes), .outValid(outValid), .outLast(outLast)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (overflow || (outValid && $stable(outData)
      && $stable(outLast) && $stable(outDestIp)))); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!outValid && !overflow && !almostFull)); // R1

endmodule

// File: tb/udp_tx_framer_test.sv
module udp_tx_framer_test;

  localparam int PERIOD = 10;
  localparam int DEPTH = 2048;
  localparam int MARGIN = 16;
  localparam logic [15:0] SRC = 16'hBEEF;
  localparam int NV = 6;
  // {mode[3:0], words[15:0], ip[31:0], port[15:0]}; mode bit0 = input gaps, bit1 = throttled ready
  localparam logic [67:0] VEC [NV] = '{
    {4'h0, 16'd1,  32'hC0A80101, 16'd50000},
    {4'h1, 16'd2,  32'h0A000002, 16'd49152},
    {4'h2, 16'd5,  32'h7F000001, 16'd1234},
    {4'h3, 16'd17, 32'h12345678, 16'd65535},
    {4'h0, 16'd3,  32'hFFFFFFFF, 16'hFFFF},
    {4'h2, 16'd8,  32'h00000000, 16'd0}
  };

  logic clk = 0, rst = 1;
  logic [63:0] inData = '0;
  logic inValid = 0, inLast = 0;
  logic [31:0] inDestIp = '0;
  logic [15:0] inDestPort = '0;
  logic outReady;
  logic almostFull, overflow, outValid, outLast;
  logic [63:0] outData;
  logic [31:0] outDestIp;

  int nChk = 0, nFail = 0;
  int readyMode = 0;
  int tick = 0;
  bit done = 0;

  logic [63:0] expData [4096];
  logic        expLast [4096];
  logic [31:0] expIp   [4096];
  logic [63:0] gotData [4096];
  logic        gotLast [4096];
  logic [31:0] gotIp   [4096];
  int expN = 0, gotN = 0;

  udp_tx_framer uut (
    .clk(clk), .rst(rst), .cfgSrcPort(SRC), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inDestIp(inDestIp), .inDestPort(inDestPort),
    .almostFull(almostFull), .overflow(overflow), .outData(outData),
    .outValid(outValid), .outReady(outReady), .outLast(outLast), .outDestIp(outDestIp)
  );

  always #(PERIOD/2) clk = ~clk;

  // Ready driver: 0 always ready, 1 throttled, 2 held low
  always begin
    @(posedge clk); #1;
    tick++;
    outReady = (readyMode == 0) ? 1'b1 : (readyMode == 1) ? ((tick % 3) != 0) : 1'b0;
  end

  // Capture accepted output words away from the active edge
  always @(negedge clk) begin
    if (!rst && outValid && outReady && gotN < 4096) begin
      gotData[gotN] = outData;
      gotLast[gotN] = outLast;
      gotIp[gotN]   = outDestIp;
      gotN++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  task automatic resetDut();
    rst = 1; inValid = 0; inLast = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!outValid && !almostFull && !overflow, "R1 reset state", {61'd0, outValid, almostFull, overflow}, 64'd0);
    rst = 0;
    expN = 0; gotN = 0;
    @(posedge clk); #1;
    check(!outValid && !almostFull && !overflow, "R1 after reset", {61'd0, outValid, almostFull, overflow}, 64'd0);
  endtask

  task automatic writeWord(input logic [63:0] d, input bit last, input logic [31:0] ip, input logic [15:0] port);
    inValid = 1; inLast = last; inData = d;
    inDestIp = last ? ip : ~ip;
    inDestPort = last ? port : ~port;
    @(posedge clk); #1;
    inValid = 0; inLast = 0; inDestIp = ~ip; inDestPort = ~port;
  endtask

  task automatic sendFrame(input int n, input logic [31:0] ip, input logic [15:0] port,
                           input logic [31:0] seed, input bit gaps, input bit record);
    if (record) begin
      expData[expN] = {SRC, port, 16'((n << 3) + 8), 16'h0000};
      expLast[expN] = 0; expIp[expN] = ip; expN++;
    end
    for (int i = 0; i < n; i++) begin
      if (record) begin
        expData[expN] = {seed, 32'(i)};
        expLast[expN] = (i == n - 1); expIp[expN] = ip; expN++;
      end
      writeWord({seed, 32'(i)}, i == n - 1, ip, port);
      if (gaps && (i % 2 == 0)) begin
        inData = 64'hDEAD_DEAD_DEAD_DEAD;
        @(posedge clk); #1;
      end
    end
  endtask

  task automatic waitDrain();
    int t = 0;
    while (gotN < expN && t < 20000) begin
      @(negedge clk); t++;
    end
    repeat (5) @(negedge clk);
    if (t >= 20000) check(0, "R3 drain timeout", 64'(gotN), 64'(expN));
  endtask

  task automatic compareStream(input string ctx);
    check(gotN == expN, {ctx, " R3 word count"}, 64'(gotN), 64'(expN));
    for (int i = 0; i < expN && i < gotN; i++) begin
      check(gotData[i] == expData[i], expLast[i] || i == 0 || gotData[i][63:48] != SRC ?
            {ctx, " R2/R3 data"} : {ctx, " R2/R3 data"}, gotData[i], expData[i]);
      check(gotLast[i] == expLast[i], {ctx, " R3 last flag"}, 64'(gotLast[i]), 64'(expLast[i]));
      check(gotIp[i] == expIp[i], {ctx, " R4 dest ip"}, 64'(gotIp[i]), 64'(expIp[i]));
    end
    expN = 0; gotN = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    summary();
  end

  initial begin
    outReady = 1;
    resetDut();

    // Vector table: R2, R3, R4, R10 (throttled ready)
    for (int v = 0; v < NV; v++) begin
      readyMode = VEC[v][65] ? 1 : 0;
      sendFrame(int'(VEC[v][63:48]), VEC[v][47:16], VEC[v][15:0], 32'hA500_0000 + 32'(v), VEC[v][64], 1);
      waitDrain();
      compareStream($sformatf("vec%0d", v));
    end

    // R6: frames written back to back while earlier ones drain
    readyMode = 1;
    sendFrame(4, 32'h01020304, 16'd50001, 32'h6600_0001, 0, 1);
    sendFrame(1, 32'h05060708, 16'd50002, 32'h6600_0002, 0, 1);
    sendFrame(6, 32'h090A0B0C, 16'd50003, 32'h6600_0003, 1, 1);
    waitDrain();
    compareStream("R6 queued frames");

    // R5: 1088-word frame held behind a stalled output
    readyMode = 2;
    sendFrame(1088, 32'hC0A80A0A, 16'd60000, 32'h5500_0000, 0, 1);
    check(!overflow, "R5 no overflow on max frame", 64'(overflow), 64'd0);
    check(gotN == 0, "R10 stall holds output", 64'(gotN), 64'd0);
    readyMode = 0;
    waitDrain();
    compareStream("R5 max frame");

    // R7, R8, R9: fill to threshold, to full, then overflow
    resetDut();
    readyMode = 2;
    for (int i = 0; i < DEPTH - MARGIN - 1; i++) writeWord(64'(i), 0, 32'h1, 16'h1);
    check(!almostFull, "R7 below threshold", 64'(almostFull), 64'd0);
    writeWord(64'hAA, 0, 32'h1, 16'h1);
    check(almostFull, "R7 at threshold", 64'(almostFull), 64'd1);
    for (int i = DEPTH - MARGIN; i < DEPTH; i++) writeWord(64'(i), 0, 32'h1, 16'h1);
    check(!overflow, "R8 full but no overflow", 64'(overflow), 64'd0);
    writeWord(64'hBB, 0, 32'h1, 16'h1);
    check(overflow, "R8 overflow set", 64'(overflow), 64'd1);
    readyMode = 0;
    writeWord(64'hCC, 1, 32'h2, 16'h2);
    repeat (20) begin
      @(posedge clk); #1;
      check(!outValid, "R9 output locked", 64'(outValid), 64'd0);
    end
    check(overflow, "R8 overflow sticky", 64'(overflow), 64'd1);
    check(gotN == 0, "R9 nothing sent", 64'(gotN), 64'd0);

    // R11: reset clears the lock and normal traffic resumes
    resetDut();
    check(!overflow && !almostFull, "R11 cleared", {62'd0, overflow, almostFull}, 64'd0);
    sendFrame(2, 32'hAC100001, 16'd55555, 32'h7700_0000, 0, 1);
    waitDrain();
    compareStream("R11 recovery");

    // R8: closing a frame with the descriptor queue full
    readyMode = 2;
    for (int f = 0; f < 4; f++) sendFrame(1, 32'(f), 16'(f), 32'(f), 0, 0);
    check(!overflow, "R8 descriptor queue full, no overflow", 64'(overflow), 64'd0);
    sendFrame(1, 32'h9, 16'h9, 32'h9, 0, 0);
    check(overflow, "R8 descriptor overflow", 64'(overflow), 64'd1);
    resetDut();

    summary();
  end

endmodule